// File: doc/BRIEF.md
# Two-Wire Register-File Slave

This block sits on a two-wire serial bus as a slave and gives a bus master read and write access to a small bank of byte-wide configuration registers. The master never addresses a register directly. It first loads an internal pointer, which it cannot read back, and then moves data bytes. The pointer steps forward after every byte. The bus lines are sampled through a synchronizer into the system clock domain. The slave drives the data line through a single active-high pull-low enable, so the open-drain pad stays outside the block.

A write transaction is: start, device address with the direction bit clear, the pointer byte, then any number of data bytes, then stop. A read transaction also loads the pointer with a write-direction header. The master then issues a repeated start and the device address with the direction bit set. The slave returns bytes until the master declines one. The pointer is checked when it is loaded and again at every byte. A refused pointer value ends the transaction. Reads that run off the end of the bank keep returning the last register. Writes that run off the end are refused.

Top module: `twi_regfile_slave`

## Requirements
- R1: After reset every register reads 0x00, the pointer is 0 and `sda_oe` is low.
- R2: A stop seen at any point returns the slave to idle. A start seen at any point abandons the byte in progress, and the slave then expects a fresh device-address byte. A partly received byte is never stored.
- R3: The first byte after a start holds a 7-bit device address (bits 7..1, MSB first) and a direction bit (bit 0: 0 = write, 1 = read). A match is acknowledged. On a mismatch the slave does not acknowledge and ignores all traffic until the next start.
- R4: The slave acknowledges a byte by pulling SDA low for the whole ninth clock. It switches its drive only while SCL is low.
- R5: The byte after a write-direction header loads the pointer. The value is accepted only if it is below DEPTH and its bit in VALID_MASK is 1. Any other value gets no acknowledge, and the slave goes idle.
- R6: Each data byte of a write is stored at the pointer and acknowledged, and the pointer then advances by one.
- R7: A bank entry whose VALID_MASK bit is 0 is a hole. During auto-increment, a byte written to a hole is acknowledged but discarded, and a read of a hole returns 0x00.
- R8: A data byte written when the pointer is above DEPTH-1 is stored nowhere. It gets no acknowledge, and the slave goes idle.
- R9: After a read-direction header, the slave sends the register at the pointer, MSB first. While the master acknowledges, it sends the following registers in increasing order.
- R10: A read with the pointer above DEPTH-1 returns the register at DEPTH-1.
- R11: A master no-acknowledge (SDA high on the ninth clock) ends the read. The slave releases SDA and goes idle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Sampled serial clock line |
| sda_i | input | 1 | Sampled serial data line |
| sda_oe | output | 1 | Pull SDA low when 1, release when 0 |

## Verification
A corrupted pointer shows up as a wrong byte on the very next read or as a misplaced refusal. It reaches the bus within one byte time, about nine SCL periods. A wrong controller state shows up as an acknowledge on the wrong clock or as a missing acknowledge, on the ninth clock of the byte where it occurs. A write landing in the wrong entry stays hidden until that entry is read back. For that reason the stimulus reads back every region it writes, including the hole, the top entry and the entries next to aborted bytes.

// File: rtl/twi_pkg.sv
`timescale 1ns/1ps
package twi_pkg;

    localparam int BYTE_W = 8;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_SUB,
        ST_SUB_ACK,
        ST_WR,
        ST_WR_ACK,
        ST_TX,
        ST_MACK
    } twi_state_e;

endpackage

// File: rtl/twi_line_sync.sv
`timescale 1ns/1ps
module twi_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_lvl,
    output logic sda_lvl,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);

    typedef struct packed {
        logic [STAGES-1:0] scl_sh;
        logic [STAGES-1:0] sda_sh;
        logic              scl_p;
        logic              sda_p;
    } sync_t;

    sync_t q, d;

    always_comb begin
        d        = q;
        d.scl_sh = {q.scl_sh[STAGES-2:0], scl_i};
        d.sda_sh = {q.sda_sh[STAGES-2:0], sda_i};
        d.scl_p  = q.scl_sh[STAGES-1];
        d.sda_p  = q.sda_sh[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '1;
        end else begin
            q <= d;
        end
    end

    assign scl_lvl   = q.scl_sh[STAGES-1];
    assign sda_lvl   = q.sda_sh[STAGES-1];
    assign scl_rise  = scl_lvl & ~q.scl_p;
    assign scl_fall  = ~scl_lvl & q.scl_p;
    assign start_det = scl_lvl & q.scl_p & q.sda_p & ~sda_lvl;
    assign stop_det  = scl_lvl & q.scl_p & ~q.sda_p & sda_lvl;

endmodule

// File: rtl/twi_regbank.sv
`timescale 1ns/1ps
module twi_regbank #(
    parameter int               DEPTH      = 16,
    parameter logic [DEPTH-1:0] VALID_MASK = '1,
    parameter int               AW         = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [7:0]    wr_data,
    input  logic [AW-1:0] rd_addr,
    output logic [7:0]    rd_data
);

    localparam logic [AW-1:0] TOP_P = AW'(DEPTH - 1);

    logic [7:0]    ents [DEPTH];
    logic [AW-1:0] rd_idx;

    for (genvar i = 0; i < DEPTH; i++) begin : g_ent
        if (VALID_MASK[i]) begin : g_store
            logic [7:0] val_d, val_q;
            always_comb begin
                val_d = val_q;
                if (wr_en && wr_addr == AW'(i)) begin
                    val_d = wr_data;
                end
            end
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    val_q <= '0;
                end else begin
                    val_q <= val_d;
                end
            end
            assign ents[i] = val_q;
        end else begin : g_hole
            assign ents[i] = '0;
        end
    end

    always_comb begin
        rd_idx  = (rd_addr > TOP_P) ? TOP_P : rd_addr;
        rd_data = ents[rd_idx];
    end

    // R8: the controller never issues a store beyond the top entry
    p_store_in_range_r8: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (wr_addr <= TOP_P));

endmodule

// File: rtl/twi_slave_ctrl.sv
`timescale 1ns/1ps
module twi_slave_ctrl
    import twi_pkg::*;
#(
    parameter logic [6:0]       DEV_ADDR   = 7'h2A,
    parameter int               DEPTH      = 16,
    parameter logic [DEPTH-1:0] VALID_MASK = '1,
    parameter int               AW         = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          scl_lvl,
    input  logic          sda_lvl,
    input  logic          scl_rise,
    input  logic          scl_fall,
    input  logic          start_det,
    input  logic          stop_det,
    input  logic [7:0]    rd_data,
    output logic [AW-1:0] rd_addr,
    output logic          wr_en,
    output logic [AW-1:0] wr_addr,
    output logic [7:0]    wr_data,
    output logic          sda_oe
);

    localparam int            IW     = AW - 1;
    localparam logic [AW-1:0] TOP_P  = AW'(DEPTH - 1);
    localparam logic [AW-1:0] LIM_P  = AW'(DEPTH);
    localparam logic [7:0]    DEPTH8 = 8'(DEPTH);

    typedef struct packed {
        twi_state_e    st;
        logic [3:0]    cnt;
        logic [7:0]    sh;
        logic          rw;
        logic          mack;
        logic          oe;
        logic [AW-1:0] ptr;
    } ctrl_t;

    ctrl_t q, d;

    logic          sub_ok;
    logic [AW-1:0] ptr_inc;

    always_comb begin
        sub_ok  = (q.sh < DEPTH8) && VALID_MASK[q.sh[IW-1:0]];
        ptr_inc = (q.ptr >= LIM_P) ? LIM_P : q.ptr + AW'(1);
    end

    always_comb begin
        d       = q;
        wr_en   = 1'b0;
        wr_addr = q.ptr;
        wr_data = q.sh;
        if (start_det) begin
            d.st  = ST_ADDR;
            d.cnt = '0;
            d.oe  = 1'b0;
        end else if (stop_det) begin
            d.st  = ST_IDLE;
            d.cnt = '0;
            d.oe  = 1'b0;
        end else begin
            unique case (q.st)
                ST_ADDR, ST_SUB, ST_WR: begin
                    if (scl_rise && q.cnt < 4'd8) begin
                        d.sh  = {q.sh[6:0], sda_lvl};
                        d.cnt = q.cnt + 4'd1;
                    end else if (scl_fall && q.cnt == 4'd8) begin
                        d.cnt = '0;
                        d.st  = ST_IDLE;
                        if (q.st == ST_ADDR) begin
                            if (q.sh[7:1] == DEV_ADDR) begin
                                d.rw = q.sh[0];
                                d.oe = 1'b1;
                                d.st = ST_ADDR_ACK;
                            end
                        end else if (q.st == ST_SUB) begin
                            if (sub_ok) begin
                                d.ptr = {1'b0, q.sh[IW-1:0]};
                                d.oe  = 1'b1;
                                d.st  = ST_SUB_ACK;
                            end
                        end else begin
                            if (q.ptr <= TOP_P) begin
                                wr_en = 1'b1;
                                d.ptr = ptr_inc;
                                d.oe  = 1'b1;
                                d.st  = ST_WR_ACK;
                            end
                        end
                    end
                end
                ST_ADDR_ACK, ST_SUB_ACK, ST_WR_ACK: begin
                    if (scl_fall) begin
                        d.oe  = 1'b0;
                        d.cnt = '0;
                        if (q.st == ST_ADDR_ACK && q.rw) begin
                            d.sh  = {rd_data[6:0], 1'b0};
                            d.oe  = ~rd_data[7];
                            d.ptr = ptr_inc;
                            d.st  = ST_TX;
                        end else if (q.st == ST_ADDR_ACK) begin
                            d.st = ST_SUB;
                        end else begin
                            d.st = ST_WR;
                        end
                    end
                end
                ST_TX: begin
                    if (scl_rise) begin
                        d.cnt = q.cnt + 4'd1;
                    end else if (scl_fall) begin
                        if (q.cnt == 4'd8) begin
                            d.oe = 1'b0;
                            d.st = ST_MACK;
                        end else begin
                            d.oe = ~q.sh[7];
                            d.sh = {q.sh[6:0], 1'b0};
                        end
                    end
                end
                ST_MACK: begin
                    if (scl_rise) begin
                        d.mack = sda_lvl;
                        d.cnt  = 4'd9;
                    end else if (scl_fall && q.cnt == 4'd9) begin
                        d.cnt = '0;
                        if (q.mack) begin
                            d.st = ST_IDLE;
                        end else begin
                            d.sh  = {rd_data[6:0], 1'b0};
                            d.oe  = ~rd_data[7];
                            d.ptr = ptr_inc;
                            d.st  = ST_TX;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{st: ST_IDLE, cnt: '0, sh: '0, rw: 1'b0,
                   mack: 1'b0, oe: 1'b0, ptr: '0};
        end else begin
            q <= d;
        end
    end

    assign rd_addr = q.ptr;
    assign sda_oe  = q.oe;

    // R4: drive may only begin while the clock line is low
    p_drive_on_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.oe) |-> !$past(scl_lvl));

    // R2: stop always lands in idle
    p_stop_idles_r2: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> (q.st == ST_IDLE));

    // R2: start always restarts address reception
    p_start_restarts_r2: assert property (@(posedge clk) disable iff (!rst_n)
        start_det |=> (q.st == ST_ADDR && q.cnt == 4'd0));

    // R11: idle never pulls the line
    p_idle_released_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_IDLE) |-> !q.oe);

    // R10: pointer never runs beyond one past the top entry
    p_ptr_bounded_r10: assert property (@(posedge clk) disable iff (!rst_n)
        q.ptr <= LIM_P);

endmodule

// File: rtl/twi_regfile_slave.sv
`timescale 1ns/1ps
module twi_regfile_slave #(
    parameter logic [6:0]       DEV_ADDR    = 7'h2A,
    parameter int               DEPTH       = 16,
    parameter logic [DEPTH-1:0] VALID_MASK  = 16'hEFFF,
    parameter int               SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_oe
);

    localparam int AW = $clog2(DEPTH) + 1;

    logic          scl_lvl, sda_lvl, scl_rise, scl_fall, start_det, stop_det;
    logic          wr_en;
    logic [AW-1:0] wr_addr, rd_addr;
    logic [7:0]    wr_data, rd_data;

    twi_line_sync #(
        .STAGES(SYNC_STAGES)
    ) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_i    (scl_i),
        .sda_i    (sda_i),
        .scl_lvl  (scl_lvl),
        .sda_lvl  (sda_lvl),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall),
        .start_det(start_det),
        .stop_det (stop_det)
    );

    twi_slave_ctrl #(
        .DEV_ADDR  (DEV_ADDR),
        .DEPTH     (DEPTH),
        .VALID_MASK(VALID_MASK),
        .AW        (AW)
    ) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_lvl  (scl_lvl),
        .sda_lvl  (sda_lvl),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall),
        .start_det(start_det),
        .stop_det (stop_det),
        .rd_data  (rd_data),
        .rd_addr  (rd_addr),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .sda_oe   (sda_oe)
    );

    twi_regbank #(
        .DEPTH     (DEPTH),
        .VALID_MASK(VALID_MASK),
        .AW        (AW)
    ) u_bank (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_en),
        .wr_addr(wr_addr),
        .wr_data(wr_data),
        .rd_addr(rd_addr),
        .rd_data(rd_data)
    );

endmodule

// File: tb/sim_twi_regfile_slave.sv
`timescale 1ns/1ps
module sim_twi_regfile_slave;

    localparam int Q = 8;
    localparam logic [7:0] HW = 8'h54;   // device 0x2A, write
    localparam logic [7:0] HR = 8'h55;   // device 0x2A, read

    typedef struct {
        string      tag;
        logic [7:0] v;
    } item_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl = 1'b1;
    logic m_sda = 1'b1;
    logic sda_oe;
    logic sda_line;

    item_t exp_q[$];
    item_t obs_q[$];
    int    checks = 0;
    int    errors = 0;
    bit    done = 1'b0;

    always #4 clk = ~clk;

    assign sda_line = m_sda & ~sda_oe;

    twi_regfile_slave u0 (
        .clk   (clk),
        .rst_n (rst_n),
        .scl_i (scl),
        .sda_i (sda_line),
        .sda_oe(sda_oe)
    );

    // monitor: compares each observed bus item with the next expected one
    always @(negedge clk) begin
        if (obs_q.size() > 0) begin
            item_t o;
            o = obs_q.pop_front();
            checks++;
            if (exp_q.size() == 0) begin
                errors++;
                $display("FAIL unexpected item: got %02h expected none", o.v);
            end else begin
                item_t e;
                e = exp_q.pop_front();
                if (o.v !== e.v) begin
                    errors++;
                    $display("FAIL %s: got %02h expected %02h", e.tag, o.v, e.v);
                end
            end
        end
    end

    task automatic hold(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check_oe(input string tag, input logic exp);
        checks++;
        if (sda_oe !== exp) begin
            errors++;
            $display("FAIL %s: sda_oe got %b expected %b", tag, sda_oe, exp);
        end
    endtask

    task automatic bus_start();
        m_sda = 1'b1; scl = 1'b1; hold(Q);
        m_sda = 1'b0; hold(Q);
        scl = 1'b0; hold(Q/2);
    endtask

    task automatic bus_rstart();
        m_sda = 1'b1; hold(Q/2);
        scl = 1'b1; hold(Q);
        m_sda = 1'b0; hold(Q);
        scl = 1'b0; hold(Q/2);
    endtask

    task automatic bus_stop();
        m_sda = 1'b0; hold(Q/2);
        scl = 1'b1; hold(Q);
        m_sda = 1'b1; hold(Q);
    endtask

    task automatic clk_bit(input logic b, output logic s);
        m_sda = b; hold(Q/2);
        scl = 1'b1; hold(Q/2);
        s = sda_line; hold(Q/2);
        scl = 1'b0; hold(Q/2);
    endtask

    task automatic send_bits(input logic [7:0] b, input int n);
        logic s;
        for (int i = 7; i > 7 - n; i--) clk_bit(b[i], s);
    endtask

    // driver: expected acknowledge bit (0 ack, 1 no-ack) then the byte
    task automatic put(input logic [7:0] b, input logic exp_nack, input string tag);
        item_t e, o;
        logic  s;
        e.tag = tag; e.v = {7'd0, exp_nack};
        exp_q.push_back(e);
        send_bits(b, 8);
        clk_bit(1'b1, s);
        o.tag = tag; o.v = {7'd0, s};
        obs_q.push_back(o);
    endtask

    task automatic get(input logic [7:0] exp_v, input logic nack, input string tag);
        item_t e, o;
        logic  s;
        logic [7:0] v;
        e.tag = tag; e.v = exp_v;
        exp_q.push_back(e);
        v = '0;
        for (int i = 0; i < 8; i++) begin
            clk_bit(1'b1, s);
            v = {v[6:0], s};
        end
        clk_bit(nack, s);
        o.tag = tag; o.v = v;
        obs_q.push_back(o);
    endtask

    task automatic read_one(input logic [7:0] sub, input logic [7:0] exp_v, input string tag);
        bus_start();
        put(HW, 1'b0, tag);
        put(sub, 1'b0, tag);
        bus_rstart();
        put(HR, 1'b0, tag);
        get(exp_v, 1'b1, tag);
        bus_stop();
    endtask

    initial begin
        hold(150000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        hold(5);
        check_oe("R1 in reset", 1'b0);
        rst_n = 1'b1;
        hold(5);
        check_oe("R1 after reset", 1'b0);
        read_one(8'd3, 8'h00, "R1 cleared register");

        // R6 / R9: write three bytes then read them back with a repeated start
        bus_start();
        put(HW, 1'b0, "R3 address match");
        put(8'd3, 1'b0, "R5 pointer load");
        put(8'hAA, 1'b0, "R6 write 3");
        put(8'h55, 1'b0, "R6 write 4");
        put(8'hC3, 1'b0, "R6 write 5");
        bus_stop();
        bus_start();
        put(HW, 1'b0, "R9 header");
        put(8'd3, 1'b0, "R9 pointer");
        bus_rstart();
        put(HR, 1'b0, "R9 read header");
        get(8'hAA, 1'b0, "R9 read 3");
        get(8'h55, 1'b0, "R9 read 4");
        get(8'hC3, 1'b1, "R11 last read");
        hold(2);
        check_oe("R11 released after master nack", 1'b0);
        bus_stop();

        // R3: foreign address is ignored until the next start
        bus_start();
        put(8'h56, 1'b1, "R3 address mismatch");
        put(8'd3, 1'b1, "R3 ignored byte");
        bus_stop();
        read_one(8'd3, 8'hAA, "R3 register untouched");

        // R5: pointer values in a hole and beyond the bank are refused
        bus_start();
        put(HW, 1'b0, "R5 header");
        put(8'd12, 1'b1, "R5 hole pointer refused");
        put(8'h77, 1'b1, "R5 idle after refusal");
        bus_stop();
        bus_start();
        put(HW, 1'b0, "R5 header");
        put(8'd16, 1'b1, "R5 out of range pointer refused");
        bus_stop();

        // R8 / R10: run past the top entry
        bus_start();
        put(HW, 1'b0, "R8 header");
        put(8'd14, 1'b0, "R8 pointer");
        put(8'hE1, 1'b0, "R6 write 14");
        put(8'hF2, 1'b0, "R6 write 15");
        put(8'h99, 1'b1, "R8 write past top refused");
        put(8'h98, 1'b1, "R8 idle after refusal");
        bus_stop();
        bus_start();
        put(HW, 1'b0, "R10 header");
        put(8'd14, 1'b0, "R10 pointer");
        bus_rstart();
        put(HR, 1'b0, "R10 read header");
        get(8'hE1, 1'b0, "R10 read 14");
        get(8'hF2, 1'b0, "R10 read 15");
        get(8'hF2, 1'b0, "R10 past top repeats");
        get(8'hF2, 1'b1, "R10 past top repeats again");
        bus_stop();
        read_one(8'd0, 8'h00, "R8 refused byte not in entry 0");

        // R7: auto-increment across the hole at 12
        bus_start();
        put(HW, 1'b0, "R7 header");
        put(8'd11, 1'b0, "R7 pointer");
        put(8'h11, 1'b0, "R7 write 11");
        put(8'h22, 1'b0, "R7 write hole acked");
        put(8'h33, 1'b0, "R7 write 13");
        bus_stop();
        bus_start();
        put(HW, 1'b0, "R7 header");
        put(8'd11, 1'b0, "R7 pointer");
        bus_rstart();
        put(HR, 1'b0, "R7 read header");
        get(8'h11, 1'b0, "R7 read 11");
        get(8'h00, 1'b0, "R7 hole reads zero");
        get(8'h33, 1'b1, "R7 read 13");
        bus_stop();

        // R2: stop inside a data byte stores nothing
        bus_start();
        put(HW, 1'b0, "R2 header");
        put(8'd5, 1'b0, "R2 pointer");
        send_bits(8'h0F, 4);
        bus_stop();
        read_one(8'd5, 8'hC3, "R2 stop mid byte");

        // R2: start inside the pointer byte restarts address reception
        bus_start();
        put(HW, 1'b0, "R2 header");
        send_bits(8'h04, 4);
        bus_rstart();
        put(HW, 1'b0, "R2 fresh header accepted");
        put(8'd5, 1'b0, "R2 pointer");
        put(8'h66, 1'b0, "R2 write 5");
        bus_stop();
        read_one(8'd5, 8'h66, "R2 restart then write");
        read_one(8'd4, 8'h55, "R2 neighbour untouched");

        // R1: reset mid-life clears the bank
        rst_n = 1'b0;
        hold(4);
        rst_n = 1'b1;
        hold(4);
        read_one(8'd3, 8'h00, "R1 reset clears");

        hold(20);
        while (exp_q.size() > 0) begin
            item_t e;
            e = exp_q.pop_front();
            checks++;
            errors++;
            $display("FAIL %s: got nothing expected %02h", e.tag, e.v);
        end
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule